// File: doc/BRIEF.md
# Program/Erase Completion Status Reporter

This block shapes the read data that a host sees while a nonvolatile array runs a self-timed program or erase cycle. It sits between the array read path and the host data bus. While a cycle is busy, each read returns a status byte instead of array contents. Once the cycle ends, reads return array data again.

The status byte carries two indicators that work together. The top bit is a polarity flag. During a page write it returns the inverse of the top bit of the last byte the host loaded, so it equals the true data bit only when the write is done. The bit just below it is a toggle flag. It changes on every status read while the cycle runs, so two reads that agree mean the cycle has finished. During a chip erase only the toggle flag means anything. The other bits are driven to fixed values there.

The block samples the operation type and the last loaded byte on the cycle where busy rises. A read is requested with a one-cycle strobe. The result appears on the registered output one clock later and stays there until the next strobe.

Top module: `wr_status_reporter`

## Requirements
- R1: During reset and after it, until the first read strobe, `rd_data_o` is all zeros.
- R2: A strobe while `busy_i` is low puts `array_rd_i` on `rd_data_o` unchanged, on the clock after the strobe.
- R3: In a cycle with no read strobe, `rd_data_o` keeps its value.
- R4: Take a read during a busy page write (`op_kind_i` = 0). It returns bit 7 as the inverse of bit 7 of `last_byte_i`, sampled in the cycle where `busy_i` rose. Changes to `last_byte_i` later in the same busy cycle have no effect.
- R5: The first status read of each busy cycle returns bit 6 as 1. This holds even when that read falls in the cycle where `busy_i` rises.
- R6: Successive reads within one busy cycle alternate bit 6. Clock cycles without a strobe do not advance it.
- R7: A read during a busy chip erase (`op_kind_i` = 1) returns bit 7 as 0, bit 6 as the toggle flag and bits 5..0 as 1.
- R8: A read during a busy page write returns bits 5..0 from `array_rd_i`.
- R9: Each new busy cycle samples its own operation type and restarts the toggle flag. The flag's value at the end of the previous cycle does not matter, and neither does a change of `op_kind_i` during the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | High while the internal program/erase cycle runs |
| op_kind_i | input | 1 | 0 = page write, 1 = chip erase; sampled when busy rises |
| last_byte_i | input | DATA_W | Last byte loaded by the host; sampled when busy rises |
| array_rd_i | input | DATA_W | Data read from the array |
| rd_stb_i | input | 1 | One-cycle read request |
| rd_data_o | output | DATA_W | Registered read data or status |

## Verification
The bench uses the default 8-bit data width. With that width the polarity flag is bit 7 and the toggle flag is bit 6, so every expected byte can be written out in full. The stimulus covers these cases:
- back-to-back busy cycles that switch between write and erase;
- a strobe that lands in the same cycle as the busy rise;
- idle gaps between reads, which must not advance the toggle;
- changes to the sampled inputs in the middle of a cycle.

Together these reach the toggle restart and the sampling point.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;

    typedef enum logic [0:0] {
        OP_PAGE_WRITE = 1'b0,
        OP_CHIP_ERASE = 1'b1
    } op_kind_e;

endpackage

// File: rtl/wr_status_toggle.sv
module wr_status_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic rd_stb_i,
    output logic start_o,
    output logic tog_o
);

    typedef struct packed {
        logic busy;
        logic tog;
    } tog_state_t;

    tog_state_t st_d, st_q;
    logic       tog_cur;

    always_comb begin
        st_d     = st_q;
        start_o  = busy_i & ~st_q.busy;
        tog_cur  = start_o ? 1'b1 : st_q.tog;
        st_d.busy = busy_i;
        if (rd_stb_i && busy_i) begin
            st_d.tog = ~tog_cur;
        end else begin
            st_d.tog = tog_cur;
        end
        tog_o = tog_cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, tog: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && busy_i && !start_o) |=> (st_q.tog != $past(st_q.tog)));

    // R6
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb_i && !start_o) |=> $stable(st_q.tog));

    // R5
    tog_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !rd_stb_i) |=> st_q.tog);

endmodule

// File: rtl/wr_status_capture.sv
module wr_status_capture
    import wr_status_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  op_kind_e op_kind_i,
    input  logic     poll_src_i,
    output op_kind_e op_o,
    output logic     poll_o
);

    typedef struct packed {
        op_kind_e op;
        logic     poll;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.op   = op_kind_i;
            st_d.poll = poll_src_i;
        end
        op_o   = st_d.op;
        poll_o = st_d.poll;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{op: OP_PAGE_WRITE, poll: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    cap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(st_q));

endmodule

// File: rtl/wr_status_former.sv
module wr_status_former
    import wr_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              busy_i,
    input  op_kind_e          op_i,
    input  logic              poll_i,
    input  logic              tog_i,
    input  logic [DATA_W-1:0] array_rd_i,
    output logic [DATA_W-1:0] byte_o
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    always_comb begin
        byte_o = array_rd_i;
        if (busy_i) begin
            if (op_i == OP_CHIP_ERASE) begin
                byte_o           = '1;
                byte_o[POLL_BIT] = 1'b0;
            end else begin
                byte_o[POLL_BIT] = ~poll_i;
            end
            byte_o[TOG_BIT] = tog_i;
        end
    end

endmodule

// File: rtl/wr_status_reporter.sv
module wr_status_reporter
    import wr_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              op_kind_i,
    input  logic [DATA_W-1:0] last_byte_i,
    input  logic [DATA_W-1:0] array_rd_i,
    input  logic              rd_stb_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;
    localparam int LOW_W    = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } out_state_t;

    out_state_t st_d, st_q;

    logic              start;
    logic              tog_cur;
    op_kind_e          op_cur;
    logic              poll_cur;
    logic [DATA_W-1:0] status_byte;

    wr_status_toggle u_toggle (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_i   (busy_i),
        .rd_stb_i (rd_stb_i),
        .start_o  (start),
        .tog_o    (tog_cur)
    );

    wr_status_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .op_kind_i  (op_kind_e'(op_kind_i)),
        .poll_src_i (last_byte_i[POLL_BIT]),
        .op_o       (op_cur),
        .poll_o     (poll_cur)
    );

    wr_status_former #(.DATA_W(DATA_W)) u_former (
        .busy_i     (busy_i),
        .op_i       (op_cur),
        .poll_i     (poll_cur),
        .tog_i      (tog_cur),
        .array_rd_i (array_rd_i),
        .byte_o     (status_byte)
    );

    always_comb begin
        st_d = st_q;
        if (rd_stb_i) begin
            st_d.data = status_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.data;

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> $stable(rd_data_o));

    // R2
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !busy_i) |=> (rd_data_o == $past(array_rd_i)));

    // R7
    erase_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && busy_i && op_cur == OP_CHIP_ERASE) |=>
        (!rd_data_o[POLL_BIT] && (&rd_data_o[LOW_W-1:0])));

    // R4
    poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && busy_i && op_cur == OP_PAGE_WRITE) |=>
        (rd_data_o[POLL_BIT] != $past(poll_cur)));

    // R8
    write_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && busy_i && op_cur == OP_PAGE_WRITE) |=>
        (rd_data_o[LOW_W-1:0] == $past(array_rd_i[LOW_W-1:0])));

    // R5
    first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && start) |=> rd_data_o[TOG_BIT]);

endmodule

// File: tb/wr_status_reporter_tb.sv
module wr_status_reporter_tb;

    localparam int  DW  = 8;
    localparam time CLK = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          busy_i = 1'b0;
    logic          op_kind_i = 1'b0;
    logic [DW-1:0] last_byte_i = '0;
    logic [DW-1:0] array_rd_i = '0;
    logic          rd_stb_i = 1'b0;
    logic [DW-1:0] rd_data_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic          m_busy = 1'b0;
    logic          m_tog = 1'b1;
    logic          m_op = 1'b0;
    logic          m_l7 = 1'b0;
    logic [DW-1:0] m_out = '0;

    always #(CLK/2) clk = ~clk;

    wr_status_reporter #(.DATA_W(DW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy_i),
        .op_kind_i   (op_kind_i),
        .last_byte_i (last_byte_i),
        .array_rd_i  (array_rd_i),
        .rd_stb_i    (rd_stb_i),
        .rd_data_o   (rd_data_o)
    );

    function automatic logic [DW-1:0] status_of(input logic op, input logic l7,
                                                input logic tg, input logic [DW-1:0] a);
        logic [DW-1:0] v;
        if (op) begin
            v = 8'h3F;
        end else begin
            v = {~l7, 1'b0, a[5:0]};
        end
        v[6] = tg;
        return v;
    endfunction

    task automatic check(input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (rd_data_o !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data_o=%02h expected=%02h at %0t", tag, rd_data_o, exp, $time);
        end
    endtask

    task automatic cyc(input logic b, input logic o, input logic [DW-1:0] l,
                       input logic [DW-1:0] a, input logic r, input string tag);
        logic st, tg, op, l7;
        @(negedge clk);
        busy_i = b; op_kind_i = o; last_byte_i = l; array_rd_i = a; rd_stb_i = r;
        st = b & ~m_busy;
        tg = st ? 1'b1 : m_tog;
        op = st ? o : m_op;
        l7 = st ? l[7] : m_l7;
        if (r) m_out = b ? status_of(op, l7, tg, a) : a;
        m_tog = (r && b) ? ~tg : tg;
        m_busy = b; m_op = op; m_l7 = l7;
        @(posedge clk);
        #1;
        check(m_out, tag);
    endtask

    initial begin
        #(CLK * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: expired, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #1;
        check(8'h00, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 8'h00, 8'h5A, 0, "R1");
        cyc(0, 0, 8'h00, 8'hC3, 1, "R2");
        cyc(0, 0, 8'h00, 8'h11, 0, "R3");
        // page write, last byte bit7=1, strobe in the busy rise cycle
        cyc(1, 0, 8'h80, 8'h2A, 1, "R5");
        cyc(1, 0, 8'h80, 8'h15, 1, "R6");
        cyc(1, 0, 8'h80, 8'h15, 0, "R3");
        cyc(1, 0, 8'h80, 8'h15, 0, "R6");
        cyc(1, 0, 8'h00, 8'h3C, 1, "R4");
        cyc(1, 1, 8'h00, 8'h07, 1, "R8");
        cyc(0, 0, 8'h00, 8'hE7, 1, "R2");
        // erase cycle, read not in the rise cycle
        cyc(1, 1, 8'hFF, 8'h00, 0, "R9");
        cyc(1, 0, 8'h00, 8'h00, 1, "R9");
        cyc(1, 0, 8'h00, 8'h00, 1, "R7");
        cyc(0, 0, 8'h00, 8'h42, 1, "R2");
        // back-to-back write with bit7=0
        cyc(1, 0, 8'h7F, 8'h01, 1, "R4");
        cyc(1, 0, 8'hFF, 8'h02, 1, "R6");
        cyc(0, 0, 8'h00, 8'h99, 1, "R2");

        for (int ep = 0; ep < 120; ep++) begin
            logic op;
            int idle_n, busy_n;
            op = 1'($urandom);
            idle_n = 1 + int'($urandom % 6);
            busy_n = 2 + int'($urandom % 30);
            for (int i = 0; i < idle_n; i++) begin
                logic r;
                r = ($urandom % 2) == 0;
                cyc(0, 1'($urandom), 8'($urandom), 8'($urandom), r, r ? "R2" : "R3");
            end
            for (int i = 0; i < busy_n; i++) begin
                logic r;
                r = ($urandom % 2) == 0;
                cyc(1, (i == 0) ? op : 1'($urandom), 8'($urandom), 8'($urandom), r,
                    !r ? "R3" : (op ? "R7" : "R4"));
            end
        end
        cyc(0, 0, 8'h00, 8'hA5, 1, "R2");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule